// File: doc/BRIEF.md
# CRC and Memory-Check Sequencer

This block is a register-programmed sequencer built around a 32-bit CRC engine. A data counter sets the length of a block of words. Software picks one of four operations and then starts the block:

- copy words through while computing and comparing their CRC;
- emit a constant fill word once per counted word;
- compute and compare a CRC with no output;
- check each word against a constant.

Input words come in through a small FIFO that is written over the register port. Output words leave on a valid/ready pair. Status flags report the following: the FIFO level and whether it has room, a pending output word, a pending per-word CRC result, counter expiry and compare errors. Two of these flags can raise an interrupt. Separate options make the sequencer stall until the output word is taken, or until the per-word result flag is acknowledged. In verify mode the sequencer records where the first mismatch occurred.

Top module: `crc_chk_ctrl`

Register map (word address on `addr_i`):
- 0: control.
- 1: counter (read only).
- 2: reload.
- 3: compare/fill/verify value.
- 4: polynomial.
- 5: FIFO push (write only).
- 6: interrupt enable (direct).
- 7: interrupt enable, write-1-to-set.
- 8: interrupt enable, write-1-to-clear.
- 9: status.
- 10: failure capture.
- 11: final result.
- 12: running CRC.

Control fields:
- bit 0: enable.
- bits 7:4: operation code.
- bit 8: seed the CRC with zeros.
- bit 9: seed the CRC with ones.
- bit 12: stall while an output word is pending.
- bit 13: stall while the per-word result flag is pending.

## Requirements
- R1: After reset every register reads zero, except status, which reads 0x0001_0000 (FIFO has room, level 0). `out_valid_o` and `irq_o` are low.
- R2: A block starts only on a control write with bit 0 set. That write loads the counter from reload. While bit 0 is clear, no FIFO word is consumed and the counter holds.
- R3: The CRC update runs for codes 1 (copy) and 3 (compute). For each 32-bit word, bits are taken MSB first. When `crc[31]` XOR the data bit is 1, the CRC becomes (crc<<1) XOR poly; otherwise it becomes crc<<1. On the start write, bit 8 seeds zeros; otherwise bit 9 seeds all ones. On the last word the CRC is stored in the result register. If it differs from the value register, status bit 1 (compare error) is set.
- R4: Code 1 puts each consumed word on `out_data_o`. Code 2 puts the value register on `out_data_o` once per count and does not read the FIFO.
- R5: Code 4 compares each consumed word with the value register. On the first mismatch of a block, it sets status bit 1 and copies the counter value at that word into the capture register. Later mismatches in the same block leave the capture register unchanged.
- R6: Each processed word lowers the counter by one. The step that reaches zero sets status bit 4 (count expired). Writing 1 to status bits 1, 4 or 18 clears them.
- R7: The FIFO holds at most 4 words, and a push to a full FIFO is dropped. Status bits 22:20 give the level. Status bit 16 is set while the FIFO is not full.
- R8: The interrupt enable can be written directly (address 6), with write-1-to-set (address 7) or with write-1-to-clear (address 8). Only bits 1 and 4 are kept. `irq_o` is high when an enabled status bit 1 or 4 is set.
- R9: Status bit 17 (`out_valid_o`) is set when a word is emitted and cleared when `out_ready_i` is seen. With control bit 12 set, processing halts while that flag is set. With bit 12 clear, a new word overwrites the pending one.
- R10: Status bit 18 is set after each CRC update. With control bit 13 set, processing halts until software clears bit 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on `addr_i`) |
| out_valid_o | output | 1 | Output word pending |
| out_data_o | output | 32 | Output word |
| out_ready_i | input | 1 | Consumer takes the output word |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker checks the following on every cycle:
- the FIFO level never exceeds its depth;
- the counter holds or drops by exactly one between start writes;
- a disabled block never moves its counter;
- an output stall freezes the counter while the word is pending;
- the capture register is frozen once a verify failure is recorded;
- the interrupt never rises with both enables clear.

Only the bench scenarios can show the rest: the CRC values under each seed and polynomial, the copied and fill words, the capture position, the dropped fifth push, and the three ways of writing the interrupt enable. The bench also covers release of the two stalls by the consumer handshake and by clearing bit 18.

// File: rtl/crc_ctrl_pkg.sv
package crc_ctrl_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_COPY   = 4'd1,
    OP_FILL   = 4'd2,
    OP_CALC   = 4'd3,
    OP_VERIFY = 4'd4
  } op_e;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_COUNT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD  = 4'd2;
  localparam logic [ADDR_W-1:0] A_VALUE   = 4'd3;
  localparam logic [ADDR_W-1:0] A_POLY    = 4'd4;
  localparam logic [ADDR_W-1:0] A_FIFO    = 4'd5;
  localparam logic [ADDR_W-1:0] A_IEN     = 4'd6;
  localparam logic [ADDR_W-1:0] A_IEN_SET = 4'd7;
  localparam logic [ADDR_W-1:0] A_IEN_CLR = 4'd8;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd9;
  localparam logic [ADDR_W-1:0] A_CAPTURE = 4'd10;
  localparam logic [ADDR_W-1:0] A_RESULT  = 4'd11;
  localparam logic [ADDR_W-1:0] A_CURRENT = 4'd12;

  localparam int C_EN        = 0;
  localparam int C_OP_LO     = 4;
  localparam int C_SEED0     = 8;
  localparam int C_SEED1     = 9;
  localparam int C_OBR_STALL = 12;
  localparam int C_IRR_STALL = 13;

  localparam int S_CMPERR = 1;
  localparam int S_CNTEXP = 4;
  localparam int S_IBR    = 16;
  localparam int S_OBR    = 17;
  localparam int S_IRR    = 18;
  localparam int S_LVL_LO = 20;
endpackage

// File: rtl/crc_in_fifo.sv
module crc_in_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [DW-1:0]                  data_i,
  input  logic                           pop_i,
  output logic [DW-1:0]                  data_o,
  output logic [$clog2(DEPTH+1)-1:0]     level_o,
  output logic                           full_o,
  output logic                           empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = lvl_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + LW'(1);
        2'b01:   lvl_q <= lvl_q - LW'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/crc_word_step.sv
module crc_word_step #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] crc_i,
  input  logic [DW-1:0] poly_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] crc_o
);
  always_comb begin
    logic [DW-1:0] c;
    c = crc_i;
    for (int b = DW-1; b >= 0; b--) begin
      if (c[DW-1] ^ data_i[b]) c = {c[DW-2:0], 1'b0} ^ poly_i;
      else                     c = {c[DW-2:0], 1'b0};
    end
    crc_o = c;
  end
endmodule

// File: rtl/crc_chk_ctrl.sv
module crc_chk_ctrl
  import crc_ctrl_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              out_valid_o,
  output logic [REG_W-1:0]  out_data_o,
  input  logic              out_ready_i,
  output logic              irq_o
);
  localparam int LVL_W = $clog2(FIFO_DEPTH+1);
  localparam logic [REG_W-1:0] IEN_MASK = (REG_W'(1) << S_CMPERR) | (REG_W'(1) << S_CNTEXP);

  logic [REG_W-1:0] ctrl_q, val_q, poly_q, ien_q, crc_q, result_q, out_data_q, sts;
  logic [CNT_W-1:0] cnt_q, reload_q, cap_q;
  logic             cmp_err_q, cnt_exp_q, obr_q, irr_q, vfail_q;

  logic             ctrl_wr, sts_wr, start;
  op_e              op;
  logic             mode_ok, uses_fifo, uses_crc, emits, active, hold, step, last;
  logic             crc_upd, emit, crc_fail, vrf_fail;
  logic [REG_W-1:0] fifo_rd, crc_nxt;
  logic [LVL_W-1:0] fifo_lvl;
  logic             fifo_full, fifo_empty;

  assign ctrl_wr = wr_i && (addr_i == A_CTRL);
  assign sts_wr  = wr_i && (addr_i == A_STATUS);
  assign start   = ctrl_wr && wdata_i[C_EN];

  assign op        = op_e'(ctrl_q[C_OP_LO +: 4]);
  assign mode_ok   = (op == OP_COPY) || (op == OP_FILL) || (op == OP_CALC) || (op == OP_VERIFY);
  assign uses_fifo = (op != OP_FILL);
  assign uses_crc  = (op == OP_COPY) || (op == OP_CALC);
  assign emits     = (op == OP_COPY) || (op == OP_FILL);

  assign active = ctrl_q[C_EN] && mode_ok && (cnt_q != '0) && !start;
  assign hold   = (ctrl_q[C_OBR_STALL] && obr_q) || (ctrl_q[C_IRR_STALL] && irr_q);
  assign step   = active && !hold && (!uses_fifo || !fifo_empty);
  assign last   = (cnt_q == CNT_W'(1));

  assign crc_upd  = step && uses_crc;
  assign emit     = step && emits;
  assign crc_fail = crc_upd && last && (crc_nxt != val_q);
  assign vrf_fail = step && (op == OP_VERIFY) && (fifo_rd != val_q);

  crc_in_fifo #(.DW(REG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_i && (addr_i == A_FIFO)),
    .data_i  (wdata_i),
    .pop_i   (step && uses_fifo),
    .data_o  (fifo_rd),
    .level_o (fifo_lvl),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  crc_word_step #(.DW(REG_W)) u_step (
    .crc_i  (crc_q),
    .poly_i (poly_q),
    .data_i (fifo_rd),
    .crc_o  (crc_nxt)
  );

  // software-visible configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      val_q    <= '0;
      poly_q   <= '0;
      ien_q    <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_CTRL:    ctrl_q   <= wdata_i;
        A_RELOAD:  reload_q <= wdata_i[CNT_W-1:0];
        A_VALUE:   val_q    <= wdata_i;
        A_POLY:    poly_q   <= wdata_i;
        A_IEN:     ien_q    <= wdata_i & IEN_MASK;
        A_IEN_SET: ien_q    <= ien_q | (wdata_i & IEN_MASK);
        A_IEN_CLR: ien_q    <= ien_q & ~wdata_i;
        default:   ;
      endcase
    end
  end

  // sequencer state and flags; a set in the same cycle wins over a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      crc_q      <= '0;
      result_q   <= '0;
      cap_q      <= '0;
      vfail_q    <= 1'b0;
      cmp_err_q  <= 1'b0;
      cnt_exp_q  <= 1'b0;
      irr_q      <= 1'b0;
      obr_q      <= 1'b0;
      out_data_q <= '0;
    end else begin
      if (start) begin
        cnt_q   <= reload_q;
        vfail_q <= 1'b0;
        if (wdata_i[C_SEED0])      crc_q <= '0;
        else if (wdata_i[C_SEED1]) crc_q <= '1;
      end else begin
        if (step)     cnt_q   <= cnt_q - CNT_W'(1);
        if (crc_upd)  crc_q   <= crc_nxt;
        if (vrf_fail) vfail_q <= 1'b1;
      end
      if (crc_upd && last)      result_q <= crc_nxt;
      if (vrf_fail && !vfail_q) cap_q    <= cnt_q;

      if (crc_fail || (vrf_fail && !vfail_q)) cmp_err_q <= 1'b1;
      else if (sts_wr && wdata_i[S_CMPERR])   cmp_err_q <= 1'b0;
      if (step && last)                       cnt_exp_q <= 1'b1;
      else if (sts_wr && wdata_i[S_CNTEXP])   cnt_exp_q <= 1'b0;
      if (crc_upd)                            irr_q     <= 1'b1;
      else if (sts_wr && wdata_i[S_IRR])      irr_q     <= 1'b0;

      if (emit) begin
        obr_q      <= 1'b1;
        out_data_q <= (op == OP_FILL) ? val_q : fifo_rd;
      end else if (out_ready_i) begin
        obr_q <= 1'b0;
      end
    end
  end

  always_comb begin
    sts                      = '0;
    sts[S_CMPERR]            = cmp_err_q;
    sts[S_CNTEXP]            = cnt_exp_q;
    sts[S_IBR]               = !fifo_full;
    sts[S_OBR]               = obr_q;
    sts[S_IRR]               = irr_q;
    sts[S_LVL_LO +: LVL_W]   = fifo_lvl;
  end

  always_comb begin
    case (addr_i)
      A_CTRL:                      rdata_o = ctrl_q;
      A_COUNT:                     rdata_o = REG_W'(cnt_q);
      A_RELOAD:                    rdata_o = REG_W'(reload_q);
      A_VALUE:                     rdata_o = val_q;
      A_POLY:                      rdata_o = poly_q;
      A_IEN, A_IEN_SET, A_IEN_CLR: rdata_o = ien_q;
      A_STATUS:                    rdata_o = sts;
      A_CAPTURE:                   rdata_o = REG_W'(cap_q);
      A_RESULT:                    rdata_o = result_q;
      A_CURRENT:                   rdata_o = crc_q;
      default:                     rdata_o = '0;
    endcase
  end

  assign out_valid_o = obr_q;
  assign out_data_o  = out_data_q;
  assign irq_o       = |(sts & ien_q);
endmodule

// File: rtl/crc_chk_ctrl_chk.sv
module crc_chk_ctrl_chk #(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           ctrl_wr_i,
  input logic                           en_i,
  input logic                           obr_stall_i,
  input logic                           out_valid_i,
  input logic                           out_ready_i,
  input logic                           vfail_i,
  input logic                           irq_i,
  input logic [31:0]                    ien_i,
  input logic [CNT_W-1:0]               cnt_i,
  input logic [CNT_W-1:0]               cap_i,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] level_i
);
  // R7
  lvl_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(level_i) <= FIFO_DEPTH);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ctrl_wr_i) |=> $stable(cnt_i));

  // R6
  cnt_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && cnt_i != '0) |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) - CNT_W'(1)));

  // R6
  cnt_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && cnt_i == '0) |=> cnt_i == '0);

  // R9
  obr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obr_stall_i && out_valid_i && !out_ready_i && !ctrl_wr_i) |=> ($stable(cnt_i) && out_valid_i));

  // R5
  cap_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vfail_i && !ctrl_wr_i) |=> $stable(cap_i));

  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (ien_i[1] || ien_i[4]));
endmodule

bind crc_chk_ctrl crc_chk_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_wr_i   (ctrl_wr),
  .en_i        (ctrl_q[0]),
  .obr_stall_i (ctrl_q[12]),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .vfail_i     (vfail_q),
  .irq_i       (irq_o),
  .ien_i       (ien_q),
  .cnt_i       (cnt_q),
  .cap_i       (cap_q),
  .level_i     (fifo_lvl)
);

// File: tb/crc_chk_ctrl_test.sv
module crc_chk_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  crc_chk_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ready_i(out_ready), .irq_o(irq)
  );

  typedef struct packed {
    logic [3:0]       mode;
    logic             ones;
    logic             good;
    logic [2:0]       n;
    logic [31:0]      poly;
    logic [31:0]      val;
    logic [3:0][31:0] w;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{4'd3, 1'b1, 1'b1, 3'd4, 32'h04C11DB7, 32'h0,
      '{32'hDEADBEEF, 32'h00000001, 32'h80000000, 32'h12345678}},
    '{4'd3, 1'b0, 1'b0, 3'd3, 32'h1EDC6F41, 32'h0,
      '{32'h0, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'hCAFEBABE}},
    '{4'd1, 1'b1, 1'b1, 3'd2, 32'h04C11DB7, 32'h0,
      '{32'h0, 32'h0, 32'h55AA33CC, 32'h9ABCDEF0}},
    '{4'd4, 1'b0, 1'b0, 3'd4, 32'h04C11DB7, 32'hA5A5A5A5,
      '{32'hA5A5A5A5, 32'h00000001, 32'h00000000, 32'hA5A5A5A5}},
    '{4'd4, 1'b0, 1'b0, 3'd3, 32'h04C11DB7, 32'h5A5A0F0F,
      '{32'h5A5A0F0F, 32'h5A5A0F0F, 32'h5A5A0F0F, 32'h5A5A0F0F}}
  };

  function automatic logic [31:0] crc_ref(logic [31:0] c, logic [31:0] p, logic [31:0] w);
    for (int b = 31; b >= 0; b--) begin
      if (c[31] ^ w[b]) c = {c[30:0], 1'b0} ^ p;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t        t;
    logic [31:0] rd, exp_crc, cval, c2;
    int          first_bad;
    logic        exp_err;

    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(4'd9, rd);  check("R1 status", rd, 32'h0001_0000);
    rd_reg(4'd1, rd);  check("R1 count", rd, 32'h0);
    rd_reg(4'd6, rd);  check("R1 ien", rd, 32'h0);
    rd_reg(4'd11, rd); check("R1 result", rd, 32'h0);
    check("R1 out_valid", 32'(out_valid), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // table walk: R3 R4 R5 R6 R7
    for (int v = 0; v < 5; v++) begin
      t = TBL[v];
      exp_crc = t.ones ? 32'hFFFF_FFFF : 32'h0;
      first_bad = -1;
      for (int i = 0; i < int'(t.n); i++) begin
        exp_crc = crc_ref(exp_crc, t.poly, t.w[i]);
        if (first_bad < 0 && t.w[i] != t.val) first_bad = i;
      end
      cval = (t.mode != 4'd4 && t.good) ? exp_crc : t.val;
      exp_err = (t.mode == 4'd4) ? (first_bad >= 0) : (cval != exp_crc);
      out_ready = 1'b0;
      wr_reg(4'd0, 32'h0);
      wr_reg(4'd9, 32'h0004_0012);
      wr_reg(4'd4, t.poly);
      wr_reg(4'd3, cval);
      wr_reg(4'd2, 32'(t.n));
      for (int i = 0; i < int'(t.n); i++) wr_reg(4'd5, t.w[i]);
      rd_reg(4'd9, rd); check($sformatf("R7 level v%0d", v), (rd >> 20) & 32'h7, 32'(t.n));
      wr_reg(4'd0, 32'h1 | (32'(t.mode) << 4) | (t.ones ? 32'h200 : 32'h100));
      idle(8);
      rd_reg(4'd1, rd); check($sformatf("R6 count v%0d", v), rd, 32'h0);
      rd_reg(4'd9, rd);
      check($sformatf("R6 expired v%0d", v), (rd >> 4) & 32'h1, 32'h1);
      check($sformatf("R3/R5 cmp_err v%0d", v), (rd >> 1) & 32'h1, 32'(exp_err));
      check($sformatf("R7 drained v%0d", v), (rd >> 20) & 32'h7, 32'h0);
      if (t.mode != 4'd4) begin
        rd_reg(4'd11, rd); check($sformatf("R3 result v%0d", v), rd, exp_crc);
      end else if (exp_err) begin
        rd_reg(4'd10, rd); check($sformatf("R5 capture v%0d", v), rd, 32'(int'(t.n) - first_bad));
      end
      if (t.mode == 4'd1) begin
        check("R4 copy last word", out_data, t.w[int'(t.n) - 1]);
        check("R9 overwrite valid", 32'(out_valid), 32'h1);
      end
    end

    // R2 disabled block consumes nothing
    out_ready = 1'b1;
    wr_reg(4'd4, 32'h04C11DB7);
    wr_reg(4'd0, 32'h30);
    wr_reg(4'd2, 32'd1);
    wr_reg(4'd5, 32'h1111_1111);
    idle(4);
    rd_reg(4'd9, rd); check("R2 level held", (rd >> 20) & 32'h7, 32'h1);
    rd_reg(4'd1, rd); check("R2 count held", rd, 32'h0);
    wr_reg(4'd0, 32'h131);
    idle(4);
    rd_reg(4'd11, rd); check("R2 runs after enable", rd, crc_ref(32'h0, 32'h04C11DB7, 32'h1111_1111));

    // R7 full FIFO drops fifth push
    wr_reg(4'd0, 32'h0);
    for (int i = 1; i <= 5; i++) wr_reg(4'd5, 32'(i));
    rd_reg(4'd9, rd);
    check("R7 level full", (rd >> 20) & 32'h7, 32'h4);
    check("R7 ibr low", (rd >> 16) & 32'h1, 32'h0);
    wr_reg(4'd2, 32'd4);
    wr_reg(4'd0, 32'h131);
    idle(8);
    c2 = 32'h0;
    for (int i = 1; i <= 4; i++) c2 = crc_ref(c2, 32'h04C11DB7, 32'(i));
    rd_reg(4'd11, rd); check("R7 dropped push", rd, c2);
    rd_reg(4'd9, rd);  check("R7 empty after", (rd >> 20) & 32'h7, 32'h0);

    // R8 enable access modes
    wr_reg(4'd6, 32'h2);
    rd_reg(4'd6, rd); check("R8 direct", rd, 32'h2);
    wr_reg(4'd7, 32'h10);
    rd_reg(4'd6, rd); check("R8 set", rd, 32'h12);
    wr_reg(4'd8, 32'h2);
    rd_reg(4'd6, rd); check("R8 clear", rd, 32'h10);
    check("R8 irq on expired", 32'(irq), 32'h1);
    wr_reg(4'd9, 32'h10);
    rd_reg(4'd9, rd); check("R6 w1c expired", (rd >> 4) & 32'h1, 32'h0);
    check("R8 irq cleared", 32'(irq), 32'h0);

    // R4 fill, no stall
    out_ready = 1'b0;
    wr_reg(4'd3, 32'hCAFE_F00D);
    wr_reg(4'd2, 32'd3);
    wr_reg(4'd0, 32'h121);
    idle(6);
    rd_reg(4'd1, rd); check("R4 fill count", rd, 32'h0);
    check("R4 fill word", out_data, 32'hCAFE_F00D);
    rd_reg(4'd9, rd); check("R9 obr flag", (rd >> 17) & 32'h1, 32'h1);
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
    check("R9 taken", 32'(out_valid), 32'h0);

    // R9 output stall
    wr_reg(4'd2, 32'd3);
    wr_reg(4'd0, 32'h1021);
    idle(5);
    rd_reg(4'd1, rd); check("R9 stalled count", rd, 32'h2);
    check("R9 stalled valid", 32'(out_valid), 32'h1);
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
    idle(3);
    rd_reg(4'd1, rd); check("R9 one more step", rd, 32'h1);

    // R10 result-ready stall
    out_ready = 1'b1;
    wr_reg(4'd9, 32'h0004_0012);
    wr_reg(4'd2, 32'd2);
    wr_reg(4'd5, 32'h0BAD_F00D);
    wr_reg(4'd5, 32'h7777_0001);
    wr_reg(4'd0, 32'h2131);
    idle(5);
    rd_reg(4'd1, rd); check("R10 stalled count", rd, 32'h1);
    rd_reg(4'd9, rd); check("R10 irr flag", (rd >> 18) & 32'h1, 32'h1);
    wr_reg(4'd9, 32'h0004_0000);
    idle(3);
    rd_reg(4'd1, rd); check("R10 released", rd, 32'h0);
    rd_reg(4'd11, rd);
    check("R3 result after stall", rd,
          crc_ref(crc_ref(32'h0, 32'h04C11DB7, 32'h0BAD_F00D), 32'h04C11DB7, 32'h7777_0001));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule